// File: doc/BRIEF.md
# MDIO Management Register Target

This block sits on the PHY side of a two-wire management bus. It follows the management clock and the shared data line. It picks out frames that carry its own 5-bit port address and serves a small bank of 16-bit registers behind them. Some of the registers are writable. Some return fixed identification values. Every other location reads as zero and drops writes. On a read frame the block takes over the data line after the turnaround and shifts out the register contents. On an accepted write frame it updates the register. It also gives the surrounding logic a one-cycle parallel strobe that carries the register index and the data, together with a per-register interrupt pulse.

Both frame families are decoded. Start code 01 selects direct register access. Start code 00 selects the indirect family. In the indirect family, each of the NMMD device slots keeps a 16-bit location pointer. An address frame loads that pointer, and later data frames act on the location it holds. The management clock and data line are brought into the system clock domain through a synchroniser. Bits are taken on the detected rising edges of the management clock.

Top module: `mdio_reg_target`

## Requirements
- R1: A frame is recognised only after at least PRE_LEN (default 32) consecutive 1 bits have been sampled, followed by a 0. A frame preceded by fewer ones has no effect, and a longer preamble is accepted.
- R2: A frame whose 5-bit port field (the third field, after start and opcode) differs from `phy_addr` leaves `mdio_oe` low and changes no register.
- R3: A direct write frame (start 01, opcode 01) with turnaround 10 stores its 16 data bits, MSB first, into the writable register at the 5-bit register field. It also gives one `wr_stb` cycle carrying that index and data.
- R4: A write frame whose two turnaround bits are anything other than 10 is discarded.
- R5: A write to a read-only location (indices NRW to NRW+NRO-1) or to an undefined location (index NRW+NRO and above) changes no register and raises neither `wr_stb` nor `wrf_irq`.
- R6: During a read frame the line stays undriven for the first turnaround bit, is driven 0 for the second, then carries 16 data bits MSB first. It is released after the last data bit, and it is never driven while the master drives.
- R7: Read-only index NRW+i returns bits [16i+15:16i] of RO_VALS. Undefined indices read as 0.
- R8: An accepted write to register n pulses `wrf_irq[n]`, and only that bit, in the `wr_stb` cycle, if `irq_en[n]` is set. It pulses nothing if that bit is clear.
- R9: An indirect address frame (start 00, opcode 00) loads the pointer of the device named in the fourth field. Indirect write (opcode 01) and read (opcode 11) frames then act on that pointer's location. Pointers of other devices are unaffected, and frames naming a device of NMMD or above are ignored.
- R10: An indirect read-increment frame (opcode 10) returns the pointed location and then adds one to that device's pointer. A plain indirect read does not move it.
- R11: A direct frame with opcode 00 or 11 is malformed and is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_addr | input | 5 | Port address this target answers to |
| mdc | input | 1 | Management clock from the master |
| mdio_i | input | 1 | Resolved level of the management data line |
| mdio_o | output | 1 | Level driven onto the data line when enabled |
| mdio_oe | output | 1 | Drive enable for the data line |
| irq_en | input | NREG | Per-register write interrupt enables |
| wr_stb | output | 1 | One-cycle strobe for an accepted register write |
| wr_addr | output | $clog2(NREG) | Register index of the accepted write |
| wr_data | output | 16 | Data of the accepted write |
| wrf_irq | output | NREG | Per-register write interrupt pulses |

## Verification
The bench goes after the turnaround. A target that drove the line one bit early would collide with the master, which the contention monitor catches. One that ignored the turnaround code would let a write with 11 or 00 change a register, and a later read-back shows it. Writes to identification and unmapped indices are read back unchanged, and any stray strobe is reported by the scoreboard, so a decoder that fell through to a writable slot is exposed. The indirect tests interleave two device pointers with read-increment and plain read. An increment on the wrong opcode or the wrong device would return the wrong value on the next read. The tests also cover a preamble that is too short, one that is longer than needed, a foreign port address and malformed opcodes.

// File: rtl/mdio_tgt_pkg.sv
package mdio_tgt_pkg;

  typedef enum logic [1:0] {S_HUNT, S_HDR, S_TA, S_DATA} fstate_e;

  typedef enum logic [2:0] {
    K_DIR_RD, K_DIR_WR, K_IND_ADR, K_IND_WR, K_IND_RD, K_IND_RINC, K_BAD
  } fkind_e;

  // second start bit 1 -> direct family, 0 -> indirect family
  function automatic fkind_e decode_kind(input logic st_lo, input logic [1:0] op);
    fkind_e k;
    if (st_lo) begin
      case (op)
        2'b10:   k = K_DIR_RD;
        2'b01:   k = K_DIR_WR;
        default: k = K_BAD;
      endcase
    end else begin
      case (op)
        2'b00:   k = K_IND_ADR;
        2'b01:   k = K_IND_WR;
        2'b11:   k = K_IND_RD;
        default: k = K_IND_RINC;
      endcase
    end
    return k;
  endfunction

  function automatic logic kind_reads(input fkind_e k);
    return (k == K_DIR_RD) || (k == K_IND_RD) || (k == K_IND_RINC);
  endfunction

  function automatic logic [15:0] ptr_step(input logic [15:0] p);
    return p + 16'd1;
  endfunction

endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc,
  input  logic mdio_i,
  output logic mdc_rise,
  output logic bit_val
);
  logic [STAGES-1:0] mdc_q;
  logic [STAGES-1:0] dio_q;
  logic              mdc_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_q[0] <= 1'b0;
      dio_q[0] <= 1'b1;
    end else begin
      mdc_q[0] <= mdc;
      dio_q[0] <= mdio_i;
    end
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mdc_q[g] <= 1'b0;
        dio_q[g] <= 1'b1;
      end else begin
        mdc_q[g] <= mdc_q[g-1];
        dio_q[g] <= dio_q[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mdc_prev <= 1'b0;
    else        mdc_prev <= mdc_q[STAGES-1];
  end

  assign mdc_rise = mdc_q[STAGES-1] & ~mdc_prev;
  assign bit_val  = dio_q[STAGES-1];
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_tgt_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int NMMD    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rise,
  input  logic        bit_in,
  input  logic [4:0]  phy_addr,
  input  logic [15:0] rd_data,
  output logic [15:0] rd_loc,
  output logic        cm_valid,
  output logic [15:0] cm_loc,
  output logic [15:0] cm_data,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam int PCW = $clog2(PRE_LEN + 1);
  localparam int DW  = (NMMD > 1) ? $clog2(NMMD) : 1;
  localparam logic [PCW-1:0] PRE_L  = PCW'(PRE_LEN);
  localparam logic [4:0]     NMMD_L = 5'(NMMD);

  fstate_e              state;
  fkind_e               kind;
  logic [PCW-1:0]       pre_cnt;
  logic [3:0]           cnt;
  logic [11:0]          hdr;
  logic [15:0]          loc;
  logic [DW-1:0]        dev_q;
  logic [15:0]          sh;
  logic                 ta_ok;
  logic [NMMD-1:0][15:0] ptr_q;

  // decoded header, visible for the checks
  logic [12:0] hdr_full;
  fkind_e      kind_w;
  logic        dev_ok;
  logic        frame_hit;
  logic [15:0] loc_w;
  logic [15:0] word_in;

  assign hdr_full  = {hdr, bit_in};
  assign kind_w    = decode_kind(hdr_full[12], hdr_full[11:10]);
  assign dev_ok    = hdr_full[12] || (hdr_full[4:0] < NMMD_L);
  assign frame_hit = (hdr_full[9:5] == phy_addr) && (kind_w != K_BAD) && dev_ok;
  assign loc_w     = hdr_full[12] ? {11'b0, hdr_full[4:0]} : ptr_q[hdr_full[DW-1:0]];
  assign word_in   = {sh[14:0], bit_in};
  assign rd_loc    = loc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_HUNT;
      kind     <= K_BAD;
      pre_cnt  <= '0;
      cnt      <= '0;
      hdr      <= '0;
      loc      <= '0;
      dev_q    <= '0;
      sh       <= '0;
      ta_ok    <= 1'b0;
      ptr_q    <= '0;
      mdio_o   <= 1'b1;
      mdio_oe  <= 1'b0;
      cm_valid <= 1'b0;
      cm_loc   <= '0;
      cm_data  <= '0;
    end else begin
      cm_valid <= 1'b0;
      if (rise) begin
        case (state)
          S_HUNT: begin
            if (bit_in) begin
              if (pre_cnt != PRE_L) pre_cnt <= pre_cnt + 1'b1;
            end else if (pre_cnt == PRE_L) begin
              state   <= S_HDR;
              cnt     <= '0;
              pre_cnt <= '0;
            end else begin
              pre_cnt <= '0;
            end
          end
          S_HDR: begin
            hdr <= hdr_full[11:0];
            cnt <= cnt + 1'b1;
            if (cnt == 4'd12) begin
              cnt <= '0;
              if (frame_hit) begin
                state <= S_TA;
                kind  <= kind_w;
                loc   <= loc_w;
                dev_q <= hdr_full[DW-1:0];
              end else begin
                state <= S_HUNT;
              end
            end
          end
          S_TA: begin
            cnt <= cnt + 1'b1;
            if (kind_reads(kind)) begin
              if (cnt == 4'd0) begin
                mdio_oe <= 1'b1;
                mdio_o  <= 1'b0;
              end else begin
                mdio_o <= rd_data[15];
                sh     <= {rd_data[14:0], 1'b0};
                state  <= S_DATA;
                cnt    <= '0;
              end
            end else begin
              if (cnt == 4'd0) begin
                ta_ok <= bit_in;
              end else begin
                cnt   <= '0;
                state <= (ta_ok && !bit_in) ? S_DATA : S_HUNT;
              end
            end
          end
          default: begin
            cnt <= cnt + 1'b1;
            if (kind_reads(kind)) begin
              if (cnt != 4'd15) begin
                mdio_o <= sh[15];
                sh     <= {sh[14:0], 1'b0};
              end else begin
                mdio_oe <= 1'b0;
                mdio_o  <= 1'b1;
                state   <= S_HUNT;
                cnt     <= '0;
                if (kind == K_IND_RINC) ptr_q[dev_q] <= ptr_step(ptr_q[dev_q]);
              end
            end else begin
              sh <= word_in;
              if (cnt == 4'd15) begin
                state <= S_HUNT;
                cnt   <= '0;
                if (kind == K_IND_ADR) begin
                  ptr_q[dev_q] <= word_in;
                end else begin
                  cm_valid <= 1'b1;
                  cm_loc   <= loc;
                  cm_data  <= word_in;
                end
              end
            end
          end
        endcase
      end
    end
  end

  // R1: header collection starts only after a full preamble
  p_preamble_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HDR && $past(state) == S_HUNT) |-> $past(pre_cnt) == PRE_L);

  // R6: the first driven bit is the turnaround zero
  p_ta_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);

  // R6: drive enable moves only on a management clock edge
  p_oe_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mdio_oe) || $fell(mdio_oe)) |-> $past(rise));

  // R3: no register commit while the target owns the line
  p_commit_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |-> !mdio_oe);
endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank #(
  parameter int          NRW     = 4,
  parameter int          NRO     = 2,
  parameter int          NREG    = 8,
  parameter logic [NRO*16-1:0] RO_VALS = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [15:0]             rd_loc,
  output logic [15:0]             rd_data,
  input  logic                    cm_valid,
  input  logic [15:0]             cm_loc,
  input  logic [15:0]             cm_data,
  input  logic [NREG-1:0]         irq_en,
  output logic                    wr_stb,
  output logic [$clog2(NREG)-1:0] wr_addr,
  output logic [15:0]             wr_data,
  output logic [NREG-1:0]         wrf_irq
);
  localparam int AW = $clog2(NREG);
  localparam logic [15:0] NRW_L = 16'(NRW);

  logic [NRW-1:0][15:0] rw_q;
  logic                 writable;
  logic [NREG-1:0]      hit_vec;

  assign writable = cm_valid && (cm_loc < NRW_L);

  always_comb begin
    hit_vec = '0;
    for (int i = 0; i < NRW; i++) hit_vec[i] = writable && (cm_loc == 16'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rw_q <= '0;
    end else begin
      for (int i = 0; i < NRW; i++)
        if (hit_vec[i]) rw_q[i] <= cm_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      wrf_irq <= '0;
    end else begin
      wr_stb  <= writable;
      wrf_irq <= hit_vec & irq_en;
      if (writable) begin
        wr_addr <= cm_loc[AW-1:0];
        wr_data <= cm_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NRW; i++)
      if (rd_loc == 16'(i)) rd_data = rw_q[i];
    for (int j = 0; j < NRO; j++)
      if (rd_loc == 16'(NRW + j)) rd_data = RO_VALS[j*16 +: 16];
  end

  // R5: stored values move only on a commit to a writable index
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cm_valid || cm_loc >= NRW_L) |=> $stable(rw_q));

  // R5: strobe never names a non-writable index
  p_stb_writable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ({{(16-AW){1'b0}}, wr_addr} < NRW_L));

  // R8: at most one interrupt, and only alongside a strobe
  p_irq_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wrf_irq));
  p_irq_with_stb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrf_irq) |-> wr_stb);
endmodule

// File: rtl/mdio_reg_target.sv
module mdio_reg_target #(
  parameter int          PRE_LEN     = 32,
  parameter int          NMMD        = 2,
  parameter int          NRW         = 4,
  parameter int          NRO         = 2,
  parameter int          NREG        = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [NRO*16-1:0] RO_VALS = 32'h7A21_0C35
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [4:0]              phy_addr,
  input  logic                    mdc,
  input  logic                    mdio_i,
  output logic                    mdio_o,
  output logic                    mdio_oe,
  input  logic [NREG-1:0]         irq_en,
  output logic                    wr_stb,
  output logic [$clog2(NREG)-1:0] wr_addr,
  output logic [15:0]             wr_data,
  output logic [NREG-1:0]         wrf_irq
);
  logic        rise;
  logic        bit_val;
  logic [15:0] rd_loc;
  logic [15:0] rd_data;
  logic        cm_valid;
  logic [15:0] cm_loc;
  logic [15:0] cm_data;

  mdio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdc      (mdc),
    .mdio_i   (mdio_i),
    .mdc_rise (rise),
    .bit_val  (bit_val)
  );

  mdio_frame_fsm #(.PRE_LEN(PRE_LEN), .NMMD(NMMD)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise     (rise),
    .bit_in   (bit_val),
    .phy_addr (phy_addr),
    .rd_data  (rd_data),
    .rd_loc   (rd_loc),
    .cm_valid (cm_valid),
    .cm_loc   (cm_loc),
    .cm_data  (cm_data),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
  );

  mdio_reg_bank #(.NRW(NRW), .NRO(NRO), .NREG(NREG), .RO_VALS(RO_VALS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_loc   (rd_loc),
    .rd_data  (rd_data),
    .cm_valid (cm_valid),
    .cm_loc   (cm_loc),
    .cm_data  (cm_data),
    .irq_en   (irq_en),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wrf_irq  (wrf_irq)
  );
endmodule

// File: tb/tb_mdio_reg_target.sv
module tb_mdio_reg_target;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int WD_CYCLES  = 150000;
  localparam logic [4:0] PHY = 5'h0B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mdc = 1'b0;
  logic        m_oe = 1'b0;
  logic        m_d = 1'b1;
  logic        dut_o, dut_oe;
  logic        mdio_line;
  logic [7:0]  irq_en = 8'h00;
  logic        wr_stb;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [7:0]  wrf_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit saw_oe = 0;

  logic [2:0]  qa[$];
  logic [15:0] qd[$];
  logic [7:0]  qi[$];
  string       qt[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mdio_line = dut_oe ? dut_o : (m_oe ? m_d : 1'b1);

  mdio_reg_target dut (
    .clk(clk), .rst_n(rst_n), .phy_addr(PHY), .mdc(mdc), .mdio_i(mdio_line),
    .mdio_o(dut_o), .mdio_oe(dut_oe), .irq_en(irq_en), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .wrf_irq(wrf_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic expect_wr(input logic [2:0] a, input logic [15:0] d, input logic [7:0] irq, input string tag);
    qa.push_back(a); qd.push_back(d); qi.push_back(irq); qt.push_back(tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (dut_oe) saw_oe = 1;
      if (dut_oe && m_oe) begin
        checks++; errors++;
        $display("FAIL R6 line contention: actual both driving expected one");
      end
      if ((|wrf_irq) && !wr_stb) begin
        checks++; errors++;
        $display("FAIL R8 interrupt without strobe: actual %h expected 00", wrf_irq);
      end
      if (wr_stb) begin
        if (qa.size() == 0) begin
          checks++; errors++;
          $display("FAIL R5 unexpected strobe: actual addr %0d data %h expected none", wr_addr, wr_data);
        end else begin
          string t;
          t = qt.pop_front();
          chk(t, {29'b0, wr_addr}, {29'b0, qa.pop_front()}, "strobe index");
          chk(t, {16'b0, wr_data}, {16'b0, qd.pop_front()}, "strobe data");
          chk("R8", {24'b0, wrf_irq}, {24'b0, qi.pop_front()}, "interrupt vector");
        end
      end
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic bitx(input logic drv, input logic b, output logic s, output logic oe_s);
    m_oe = drv; m_d = b;
    repeat (HALF) @(negedge clk);
    mdc = 1'b1; s = mdio_line; oe_s = dut_oe;
    repeat (HALF) @(negedge clk);
    mdc = 1'b0;
  endtask

  task automatic frame(input int pre, input logic st_lo, input logic [1:0] op,
                       input logic [4:0] pa, input logic [4:0] ra, input logic rd,
                       input logic [1:0] ta, input logic [15:0] wd,
                       output logic [15:0] q, output logic ta1_oe, output logic ta2_v,
                       output logic end_oe);
    logic s, o;
    logic [13:0] hdr;
    hdr = {1'b0, st_lo, op, pa, ra};
    q = '0;
    for (int i = 0; i < pre; i++) bitx(1'b1, 1'b1, s, o);
    for (int i = 13; i >= 0; i--) bitx(1'b1, hdr[i], s, o);
    if (rd) begin
      bitx(1'b0, 1'b1, s, o); ta1_oe = o;
      bitx(1'b0, 1'b1, s, o); ta2_v = s;
      for (int i = 0; i < 16; i++) begin
        bitx(1'b0, 1'b1, s, o);
        q = {q[14:0], s};
      end
    end else begin
      ta1_oe = 1'b0; ta2_v = 1'b0;
      bitx(1'b1, ta[1], s, o);
      bitx(1'b1, ta[0], s, o);
      for (int i = 15; i >= 0; i--) bitx(1'b1, wd[i], s, o);
    end
    bitx(1'b0, 1'b1, s, o); end_oe = o;
    m_oe = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic wr(input logic st_lo, input logic [1:0] op, input logic [4:0] pa,
                    input logic [4:0] ra, input logic [15:0] d, input logic [1:0] ta, input int pre);
    logic [15:0] q; logic a, b, c;
    frame(pre, st_lo, op, pa, ra, 1'b0, ta, d, q, a, b, c);
  endtask

  task automatic rd(input logic st_lo, input logic [1:0] op, input logic [4:0] ra,
                    input logic [15:0] exp, input string req);
    logic [15:0] q; logic a, b, c;
    frame(32, st_lo, op, PHY, ra, 1'b1, 2'b00, 16'h0, q, a, b, c);
    chk("R6", {31'b0, a}, 32'd0, "first turnaround undriven");
    chk("R6", {31'b0, b}, 32'd0, "second turnaround zero");
    chk("R6", {31'b0, c}, 32'd0, "released after data");
    chk(req, {16'b0, q}, {16'b0, exp}, "read data");
  endtask

  initial begin
    logic [15:0] q; logic a, b, c;
    repeat (5) @(negedge clk);
    chk("R6", {31'b0, dut_oe}, 32'd0, "reset drive enable");
    chk("R3", {31'b0, wr_stb}, 32'd0, "reset strobe");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    irq_en = 8'b0000_0011;

    // R3 / R8 direct writes (start 01, opcode 01, turnaround 10)
    expect_wr(3'd0, 16'h1111, 8'h01, "R3");
    wr(1'b1, 2'b01, PHY, 5'd0, 16'h1111, 2'b10, 32);
    expect_wr(3'd1, 16'hA5C3, 8'h02, "R3");
    wr(1'b1, 2'b01, PHY, 5'd1, 16'hA5C3, 2'b10, 32);
    rd(1'b1, 2'b10, 5'd1, 16'hA5C3, "R3");
    expect_wr(3'd2, 16'h0B0E, 8'h00, "R8");
    wr(1'b1, 2'b01, PHY, 5'd2, 16'h0B0E, 2'b10, 32);

    // R4 bad turnaround codes
    wr(1'b1, 2'b01, PHY, 5'd2, 16'hFFFF, 2'b11, 32);
    wr(1'b1, 2'b01, PHY, 5'd2, 16'h5A5A, 2'b00, 32);
    rd(1'b1, 2'b10, 5'd2, 16'h0B0E, "R4");

    // R5 / R7 read-only and undefined
    wr(1'b1, 2'b01, PHY, 5'd4, 16'h1234, 2'b10, 32);
    rd(1'b1, 2'b10, 5'd4, 16'h0C35, "R5");
    rd(1'b1, 2'b10, 5'd5, 16'h7A21, "R7");
    wr(1'b1, 2'b01, PHY, 5'd7, 16'h5555, 2'b10, 32);
    rd(1'b1, 2'b10, 5'd7, 16'h0000, "R5");
    rd(1'b1, 2'b10, 5'd20, 16'h0000, "R7");

    // R2 foreign port address
    saw_oe = 0;
    frame(32, 1'b1, 2'b10, 5'h0C, 5'd1, 1'b1, 2'b00, 16'h0, q, a, b, c);
    chk("R2", {16'b0, q}, 32'h0000FFFF, "foreign read leaves line high");
    chk("R2", {31'b0, saw_oe}, 32'd0, "foreign read never drives");
    wr(1'b1, 2'b01, 5'h1B, 5'd0, 16'h9999, 2'b10, 32);
    rd(1'b1, 2'b10, 5'd0, 16'h1111, "R2");

    // R1 short and long preambles
    wr(1'b1, 2'b01, PHY, 5'd0, 16'h7777, 2'b10, 20);
    rd(1'b1, 2'b10, 5'd0, 16'h1111, "R1");
    frame(40, 1'b1, 2'b10, PHY, 5'd1, 1'b1, 2'b00, 16'h0, q, a, b, c);
    chk("R1", {16'b0, q}, 32'h0000A5C3, "long preamble read");

    // R11 malformed direct opcodes
    wr(1'b1, 2'b00, PHY, 5'd0, 16'h4242, 2'b10, 32);
    wr(1'b1, 2'b11, PHY, 5'd0, 16'h4343, 2'b10, 32);
    rd(1'b1, 2'b10, 5'd0, 16'h1111, "R11");

    // R9 indirect access (start 00): address 00, write 01, read 11
    irq_en = 8'h0F;
    wr(1'b0, 2'b00, PHY, 5'd0, 16'h0003, 2'b10, 32);
    expect_wr(3'd3, 16'h3C45, 8'h08, "R9");
    wr(1'b0, 2'b01, PHY, 5'd0, 16'h3C45, 2'b10, 32);
    rd(1'b1, 2'b10, 5'd3, 16'h3C45, "R9");
    wr(1'b0, 2'b00, PHY, 5'd1, 16'h0000, 2'b10, 32);

    // R10 read-increment (opcode 10) on device 1
    rd(1'b0, 2'b10, 5'd1, 16'h1111, "R10");
    rd(1'b0, 2'b10, 5'd1, 16'hA5C3, "R10");
    rd(1'b0, 2'b11, 5'd1, 16'h0B0E, "R10");
    rd(1'b0, 2'b11, 5'd1, 16'h0B0E, "R10");
    rd(1'b0, 2'b11, 5'd0, 16'h3C45, "R9");

    // R9 device beyond range ignored
    wr(1'b0, 2'b00, PHY, 5'd5, 16'h0000, 2'b10, 32);
    wr(1'b0, 2'b01, PHY, 5'd5, 16'h6666, 2'b10, 32);
    rd(1'b0, 2'b11, 5'd1, 16'h0B0E, "R9");
    rd(1'b1, 2'b10, 5'd0, 16'h1111, "R9");

    repeat (10) @(negedge clk);
    chk("R3", qa.size(), 32'd0, "scoreboard drained");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule